// File: doc/BRIEF.md
# Dual-Convention 8-bit Parallel Host Port

This block is the target side of an 8-bit microcontroller bus. A host uses it to read and write an internal register file. Two static configuration inputs select how the host bus is read. One picks the strobe convention: either separate active-low read and write strobes, or a direction level with a single active-low data strobe. The other picks the address style: either dedicated address pins, or an address that is multiplexed onto the data bus and captured by a latch strobe. Every host pin passes through a two-flop synchroniser. All strobe edges are found in the internal clock domain.

Toward the inside, the block issues one-cycle register-file write and read pulses together with a registered address and write data. It captures the read data the register file returns and drives it on the host data bus. While it does so it raises an output enable for an external tri-state buffer. A third configuration input states whether only the low four address pins are wired. In that case the upper address bits read as zero.

Top module: `hostbus_target`

## Requirements
- R1: While reset is asserted and after it is released, with no host activity, rf_we, rf_re and bus_data_oe are 0 and bus_data_out is 0.
- R2: With cfg_strobe_style=0, a write is an active-low bus_ctl_b (write strobe) under active-low bus_cs_n, while bus_ctl_a (read strobe) is high. When bus_ctl_b rises, rf_we pulses for one cycle with the address and data present at that moment. The pulse is high in the cycle after the second rising clock edge that follows the edge first sampling the release.
- R3: With cfg_strobe_style=0, bus_ctl_a going low (bus_ctl_b high, bus_cs_n low) gives one rf_re pulse with the same latency as R2. bus_data_out carries the register-file data one cycle later.
- R4: With cfg_strobe_style=1, bus_ctl_a is the direction (0 = write, 1 = read) and bus_ctl_b is the active-low data strobe. A write commits on the rising edge of the data strobe, with the R2 latency.
- R5: With cfg_strobe_style=1 and bus_ctl_a=1, the falling edge of the data strobe starts a read, with the R3 latency and data.
- R6: bus_data_oe rises one cycle after the rf_re pulse. It stays high only while chip select and the effective read strobe are both active. It falls two edges after the edge that first samples their release.
- R7: While bus_cs_n is high, strobe activity produces no rf_we, no rf_re and no bus_data_oe, and leaves the register file unchanged.
- R8: With cfg_addr_mux=1, the address is taken from bus_data_in[5:0] on the falling edge of bus_alat. It is held for every later access until the next falling edge, in both strobe conventions.
- R9: With cfg_addr_mux=0 and cfg_wide_addr=0, rf_addr[5:4] are 0 whatever bus_addr[5:4] carry. With cfg_wide_addr=1, all six bits are used.
- R10: Each access gives exactly one register-file pulse of the right kind. rf_we and rf_re are never high together, and rf_we is never high while bus_data_oe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_strobe_style | input | 1 | 0: separate read/write strobes, 1: direction plus data strobe |
| cfg_addr_mux | input | 1 | 0: dedicated address pins, 1: address latched from data bus |
| cfg_wide_addr | input | 1 | 1: all address pins wired, 0: only the low four |
| bus_cs_n | input | 1 | Active-low chip select |
| bus_ctl_a | input | 1 | Read strobe (active low) or direction (1 = read) |
| bus_ctl_b | input | 1 | Write strobe or data strobe, active low |
| bus_alat | input | 1 | Address latch strobe, captures on falling edge |
| bus_addr | input | 6 | Dedicated address pins |
| bus_data_in | input | 8 | Host data bus, input side |
| bus_data_out | output | 8 | Host data bus, output side |
| bus_data_oe | output | 1 | Output enable for the host data bus |
| rf_addr | output | 6 | Register-file address |
| rf_wdata | output | 8 | Register-file write data |
| rf_we | output | 1 | Register-file write pulse |
| rf_re | output | 1 | Register-file read pulse |
| rf_rdata | input | 8 | Register-file read data, combinational from rf_addr |

## Verification
The bench changes host pins only on falling clock edges. A strobe edge shows on rf_we or rf_re in the cycle after the second rising edge that follows the edge first sampling the change. Each access therefore checks the pulse as still low one cycle early and high exactly on time. Read data and bus_data_oe are due one cycle after rf_re, and the enable is checked as still high one cycle after release and low the cycle after that. Latch capture is due two edges after the edge that samples the falling latch strobe, so the bench holds the address on the bus for three cycles before the data phase.

// File: rtl/hbt_pkg.sv
package hbt_pkg;

    // Strobe convention selected by cfg_strobe_style.
    typedef enum logic {
        STB_SPLIT = 1'b0,   // separate read and write strobes
        STB_DIRDS = 1'b1    // direction level plus one data strobe
    } strobe_style_e;

    // Registered view of the decoded strobes.
    typedef struct packed {
        logic rd;
        logic wr;
    } strobe_state_t;

endpackage

// File: rtl/hbt_sync.sv
module hbt_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= RST_VAL;
            end
        end else begin
            stg_q <= stg_d;
        end
    end

    assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/hbt_strobe.sv
module hbt_strobe
    import hbt_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  strobe_style_e style,
    input  logic          cs_n_s,
    input  logic          ctl_a_s,
    input  logic          ctl_b_s,
    output logic          rd_start,
    output logic          rd_hold,
    output logic          wr_end
);

    logic          rd_now;
    logic          wr_now;
    strobe_state_t st_d;
    strobe_state_t st_q;

    always_comb begin
        unique case (style)
            STB_SPLIT: begin
                // the two strobes exclude each other; both low means no access
                rd_now = !cs_n_s && !ctl_a_s && ctl_b_s;
                wr_now = !cs_n_s && !ctl_b_s && ctl_a_s;
            end
            STB_DIRDS: begin
                rd_now = !cs_n_s && !ctl_b_s &&  ctl_a_s;
                wr_now = !cs_n_s && !ctl_b_s && !ctl_a_s;
            end
        endcase
        rd_start = rd_now && !st_q.rd;
        rd_hold  = rd_now &&  st_q.rd;
        wr_end   = st_q.wr && !wr_now;
        st_d.rd  = rd_now;
        st_d.wr  = wr_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R10: a read and a write are never both in progress
    p_rd_wr_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.rd && st_q.wr));

    // R3: a held read always follows its start or a previous hold
    p_hold_after_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hold |-> $past(rd_start || rd_hold));

endmodule

// File: rtl/hbt_addr.sv
module hbt_addr #(
    parameter int ADDR_W   = 6,
    parameter int NARROW_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_mux,
    input  logic              cfg_wide,
    input  logic              alat_s,
    input  logic [ADDR_W-1:0] pins_s,
    input  logic [ADDR_W-1:0] ad_s,
    output logic [ADDR_W-1:0] addr_eff
);

    typedef struct packed {
        logic              alat;
        logic [ADDR_W-1:0] latch;
    } addr_state_t;

    addr_state_t       st_d;
    addr_state_t       st_q;
    logic [ADDR_W-1:0] narrow;

    // Unwired upper pins read as zero.
    for (genvar i = 0; i < ADDR_W; i++) begin : g_mask
        if (i < NARROW_W) begin : g_keep
            assign narrow[i] = pins_s[i];
        end else begin : g_zero
            assign narrow[i] = 1'b0;
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.alat = alat_s;
        if (st_q.alat && !alat_s) begin
            st_d.latch = ad_s;
        end
        if (cfg_mux) begin
            addr_eff = st_q.latch;
        end else if (cfg_wide) begin
            addr_eff = pins_s;
        end else begin
            addr_eff = narrow;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R8: the latched address only moves after a falling latch strobe
    p_latch_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(alat_s) |=> $stable(st_q.latch));

endmodule

// File: rtl/hostbus_target.sv
module hostbus_target
    import hbt_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 6,
    parameter int NARROW_W    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_strobe_style,
    input  logic              cfg_addr_mux,
    input  logic              cfg_wide_addr,
    input  logic              bus_cs_n,
    input  logic              bus_ctl_a,
    input  logic              bus_ctl_b,
    input  logic              bus_alat,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data_in,
    output logic [DATA_W-1:0] bus_data_out,
    output logic              bus_data_oe,
    output logic [ADDR_W-1:0] rf_addr,
    output logic [DATA_W-1:0] rf_wdata,
    output logic              rf_we,
    output logic              rf_re,
    input  logic [DATA_W-1:0] rf_rdata
);

    localparam int CTL_W  = 4;
    localparam int PATH_W = ADDR_W + DATA_W;
    // idle levels: chip select, both strobes high; latch strobe low
    localparam logic [CTL_W-1:0] CTL_IDLE = 4'b1110;

    typedef struct packed {
        logic              we;
        logic              re;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] dout;
        logic              oe;
    } top_state_t;

    logic [CTL_W-1:0]  ctl_s;
    logic [PATH_W-1:0] path_s;
    logic [ADDR_W-1:0] pins_s;
    logic [DATA_W-1:0] data_s;
    logic [ADDR_W-1:0] addr_eff;
    logic              rd_start;
    logic              rd_hold;
    logic              wr_end;
    top_state_t        st_d;
    top_state_t        st_q;

    hbt_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_IDLE)) u_sync_ctl (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({bus_cs_n, bus_ctl_a, bus_ctl_b, bus_alat}),
        .dout (ctl_s)
    );

    hbt_sync #(.W(PATH_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_path (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({bus_addr, bus_data_in}),
        .dout (path_s)
    );

    assign pins_s = path_s[PATH_W-1:DATA_W];
    assign data_s = path_s[DATA_W-1:0];

    hbt_strobe u_strobe (
        .clk     (clk),
        .rst_n   (rst_n),
        .style   (strobe_style_e'(cfg_strobe_style)),
        .cs_n_s  (ctl_s[3]),
        .ctl_a_s (ctl_s[2]),
        .ctl_b_s (ctl_s[1]),
        .rd_start(rd_start),
        .rd_hold (rd_hold),
        .wr_end  (wr_end)
    );

    hbt_addr #(.ADDR_W(ADDR_W), .NARROW_W(NARROW_W)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_mux (cfg_addr_mux),
        .cfg_wide(cfg_wide_addr),
        .alat_s  (ctl_s[0]),
        .pins_s  (pins_s),
        .ad_s    (data_s[ADDR_W-1:0]),
        .addr_eff(addr_eff)
    );

    always_comb begin
        st_d    = st_q;
        st_d.we = wr_end;
        st_d.re = rd_start;
        st_d.oe = rd_hold;
        if (wr_end || rd_start) begin
            st_d.addr = addr_eff;
        end
        if (wr_end) begin
            st_d.wdata = data_s;
        end
        if (st_q.re) begin
            st_d.dout = rf_rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rf_we        = st_q.we;
    assign rf_re        = st_q.re;
    assign rf_addr      = st_q.addr;
    assign rf_wdata     = st_q.wdata;
    assign bus_data_out = st_q.dout;
    assign bus_data_oe  = st_q.oe;

    // R10: write pulses last one cycle
    p_we_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |=> !rf_we);

    // R10: read pulses last one cycle
    p_re_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rf_re |=> !rf_re);

    // R10: no commit while the bus is driven
    p_no_we_with_oe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(rf_we && bus_data_oe));

    // R6: the output enable rises right after a read pulse
    p_oe_after_re_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_data_oe) |-> $past(rf_re));

    // R7: a read pulse needs chip select sampled low three edges earlier
    p_cs_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rf_re |-> !$past(bus_cs_n, 3));

    if (NARROW_W < ADDR_W) begin : g_narrow_chk
        // R9: upper address bits are zero with only the low pins wired
        p_narrow_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (!cfg_addr_mux && !cfg_wide_addr && (rf_we || rf_re))
                |-> (rf_addr[ADDR_W-1:NARROW_W] == '0));
    end

endmodule

// File: tb/tb_hostbus_target.sv
module tb_hostbus_target;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_style = 1'b0, cfg_mux = 1'b0, cfg_wide = 1'b1;
    logic       cs_n = 1'b1, ctl_a = 1'b1, ctl_b = 1'b1, alat = 1'b0;
    logic [5:0] addr_pins = '0;
    logic [7:0] din = '0;
    logic [7:0] dout;
    logic       oe;
    logic [5:0] rf_addr;
    logic [7:0] rf_wdata, rf_rdata;
    logic       rf_we, rf_re;

    int tests = 0, fails = 0, we_cnt = 0, re_cnt = 0;
    bit done = 0;
    logic [7:0] mem [64];

    always #10 clk = ~clk;   // 50 MHz

    hostbus_target dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_strobe_style(cfg_style), .cfg_addr_mux(cfg_mux), .cfg_wide_addr(cfg_wide),
        .bus_cs_n(cs_n), .bus_ctl_a(ctl_a), .bus_ctl_b(ctl_b), .bus_alat(alat),
        .bus_addr(addr_pins), .bus_data_in(din), .bus_data_out(dout), .bus_data_oe(oe),
        .rf_addr(rf_addr), .rf_wdata(rf_wdata), .rf_we(rf_we), .rf_re(rf_re),
        .rf_rdata(rf_rdata)
    );

    // register file model
    assign rf_rdata = mem[rf_addr];
    always @(posedge clk) begin
        if (rf_we) begin
            mem[rf_addr] <= rf_wdata;
            we_cnt <= we_cnt + 1;
        end
        if (rf_re) re_cnt <= re_cnt + 1;
    end

    // {write, style, mux, wide, addr, data}
    localparam logic [17:0] VEC [12] = '{
        {1'b1, 1'b0, 1'b0, 1'b1, 6'h05, 8'hA5},
        {1'b1, 1'b0, 1'b0, 1'b1, 6'h2A, 8'h3C},
        {1'b1, 1'b1, 1'b0, 1'b1, 6'h11, 8'h5A},
        {1'b1, 1'b0, 1'b1, 1'b1, 6'h33, 8'hC3},
        {1'b1, 1'b1, 1'b1, 1'b1, 6'h07, 8'h81},
        {1'b1, 1'b0, 1'b0, 1'b0, 6'h3E, 8'h77},
        {1'b0, 1'b0, 1'b0, 1'b1, 6'h05, 8'hA5},
        {1'b0, 1'b1, 1'b0, 1'b1, 6'h2A, 8'h3C},
        {1'b0, 1'b0, 1'b1, 1'b1, 6'h11, 8'h5A},
        {1'b0, 1'b1, 1'b1, 1'b1, 6'h33, 8'hC3},
        {1'b0, 1'b1, 1'b0, 1'b0, 6'h2E, 8'h77},
        {1'b0, 1'b0, 1'b0, 1'b1, 6'h07, 8'h81}
    };

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic access(bit wr, bit moto, bit mux, bit wide, bit do_latch,
                          logic [5:0] a, logic [7:0] d, string tag);
        int we0, re0;
        logic [5:0] ea;
        ea = (mux || wide) ? a : {2'b00, a[3:0]};
        cfg_style = moto; cfg_mux = mux; cfg_wide = wide;
        if (mux && do_latch) begin
            din = {2'b00, a}; alat = 1'b1; cyc(2);
            alat = 1'b0; cyc(3);
        end
        addr_pins = a;
        we0 = we_cnt; re0 = re_cnt;
        cs_n = 1'b0;
        if (wr) begin
            din = d;
            if (moto) ctl_a = 1'b0;
            cyc(1);
            ctl_b = 1'b0; cyc(3);
            ctl_b = 1'b1;
            cyc(2); chk({tag, " early we"}, 16'(rf_we), 16'h0);
            cyc(1); chk({tag, " we"}, 16'(rf_we), 16'h1);
            chk({tag, " addr"}, 16'(rf_addr), 16'(ea));
            chk({tag, " wdata"}, 16'(rf_wdata), 16'(d));
        end else begin
            if (moto) ctl_a = 1'b1;
            cyc(1);
            if (moto) ctl_b = 1'b0; else ctl_a = 1'b0;
            cyc(2); chk({tag, " early re"}, 16'(rf_re), 16'h0);
            cyc(1); chk({tag, " re"}, 16'(rf_re), 16'h1);
            chk({tag, " addr"}, 16'(rf_addr), 16'(ea));
            chk("R6 oe not yet", 16'(oe), 16'h0);
            cyc(1); chk("R6 oe on", 16'(oe), 16'h1);
            chk({tag, " rdata"}, 16'(dout), 16'(d));
            cyc(2);
            ctl_a = 1'b1; ctl_b = 1'b1;
            cyc(2); chk("R6 oe held", 16'(oe), 16'h1);
            cyc(1); chk("R6 oe off", 16'(oe), 16'h0);
        end
        cyc(2);
        cs_n = 1'b1; ctl_a = 1'b1; ctl_b = 1'b1;
        cyc(2);
        chk("R10 we count", 16'(we_cnt - we0), wr ? 16'h1 : 16'h0);
        chk("R10 re count", 16'(re_cnt - re0), wr ? 16'h0 : 16'h1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
            $finish;
        end
    end

    initial begin
        string tag;
        int we0, re0;
        for (int i = 0; i < 64; i++) mem[i] = 8'h00;
        cyc(3);
        chk("R1 we in reset", 16'(rf_we), 16'h0);
        chk("R1 oe in reset", 16'(oe), 16'h0);
        rst_n = 1'b1;
        cyc(4);
        chk("R1 we idle", 16'(rf_we), 16'h0);
        chk("R1 re idle", 16'(rf_re), 16'h0);
        chk("R1 oe idle", 16'(oe), 16'h0);
        chk("R1 dout idle", 16'(dout), 16'h0);

        for (int i = 0; i < 12; i++) begin
            logic [17:0] v;
            v = VEC[i];
            if (v[15]) tag = "R8";
            else if (!v[14]) tag = "R9";
            else if (v[17]) tag = v[16] ? "R4" : "R2";
            else tag = v[16] ? "R5" : "R3";
            access(v[17], v[16], v[15], v[14], 1'b1, v[13:8], v[7:0], tag);
        end

        // R7: strobes with chip select high
        cfg_style = 1'b0; cfg_mux = 1'b0; cfg_wide = 1'b1;
        addr_pins = 6'h05; din = 8'hFF;
        we0 = we_cnt; re0 = re_cnt;
        ctl_b = 1'b0; cyc(4); ctl_b = 1'b1; cyc(2);
        ctl_a = 1'b0; cyc(4);
        chk("R7 oe with cs high", 16'(oe), 16'h0);
        ctl_a = 1'b1; cyc(4);
        chk("R7 no write", 16'(we_cnt - we0), 16'h0);
        chk("R7 no read", 16'(re_cnt - re0), 16'h0);
        access(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 6'h05, 8'hA5, "R7");

        // R8: latched address reused without a new latch strobe
        access(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 6'h2A, 8'h3C, "R8");
        din = 8'h11;
        access(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 6'h2A, 8'h3C, "R8");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule